// File: doc/BRIEF.md
# Stack Sequencer for a Memory Stage

This block is the stack engine of the memory stage in a 16-bit pipelined processor. It keeps the stack pointer and drives a 16-bit data-memory port: address, write data, a write strobe and a read strobe. It reads the word the memory returns in the same cycle. The stack grows upward from a fixed base. The pointer always names the next free slot, so a push writes at the pointer and a pop reads just below it.

Single-register pushes and pops take one cycle. Calls, returns, interrupt entry and return-from-interrupt save or restore a 28-bit program counter. Because the bus is only 16 bits wide, each of these needs two transfers. The upper transfer carries PC bits 27:16 with the four condition flags packed above them. During the first cycle of such a transfer `busy` is high, so the pipeline holds the command for one more cycle. In that second cycle the block finishes the pending transfer and does not decode the command input.

A push that would run past the top address, or a pop that would run below the base, raises an exception cause code. The faulting request issues no memory strobe and leaves the pointer where it was.

Top module: `stk_seq`

## Requirements
- R1: While reset is held, and after it is released, the pointer sits at the base address (default 2047). With no command, both strobes, `busy` and `cause` are 0, and `reg_rdata`, `pc_out` and `flags_out` are 0.
- R2: A register push (`cmd`=1) raises `mem_we` in the same cycle, at address equal to the pointer, with `reg_wdata` as data. It then advances the pointer by one. `busy` stays 0.
- R3: A register pop (`cmd`=2) raises `mem_re` at pointer minus one and moves the pointer down by one. `reg_rdata` holds the word that was read from the clock edge that ends that cycle.
- R4: A PC push (`cmd`=3, and `cmd`=4 behaves the same) writes `pc_in[15:0]` at the pointer with `busy`=1. In the next cycle it writes `{flags_in[3:0], pc_in[27:16]}` at pointer plus one with `busy`=0. The pointer ends two higher.
- R5: A PC pop (`cmd`=5 or 6) reads the upper word at pointer minus one with `busy`=1. In the next cycle it reads the lower word at pointer minus two with `busy`=0. After that edge `pc_out` = {4'b0, upper[11:0], lower}. The pointer ends two lower.
- R6: A plain PC pop (`cmd`=5) leaves `flags_out` unchanged. A pop with flags (`cmd`=6) loads `flags_out` from bits 15:12 of the upper word.
- R7: A pop that needs more words than lie above the base gives `cause`=2, with no strobe, `busy`=0 and the pointer unchanged.
- R8: A push that would move the pointer past the `TOP` parameter gives `cause`=1, with no strobe, `busy`=0 and the pointer unchanged.
- R9: No command (`cmd`=0) leaves the pointer alone and issues no strobe. In the second cycle of a two-word transfer the `cmd` value is not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd | input | 3 | 0 none, 1 push word, 2 pop word, 3 push PC, 4 push PC with flags, 5 pop PC, 6 pop PC with flags |
| reg_wdata | input | 16 | Register value to push |
| pc_in | input | 28 | Program counter to save |
| flags_in | input | 4 | Condition flags to save |
| mem_rdata | input | 16 | Word returned by data memory for the current address |
| mem_addr | output | 16 | Data-memory address |
| mem_wdata | output | 16 | Data-memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| reg_rdata | output | 16 | Last popped register word |
| pc_out | output | 32 | Last restored program counter, bits 31:28 zero |
| flags_out | output | 4 | Flags restored by the last pop with flags |
| busy | output | 1 | First cycle of a two-word transfer |
| cause | output | 4 | 0 none, 1 stack overflow, 2 stack underflow |

## Verification
Address, write data, strobes, `busy` and `cause` depend combinationally on the command and the pointer, so they are due in the same cycle as the command. The second word of a PC transfer is due exactly one cycle later. `reg_rdata`, `pc_out` and `flags_out` change on the clock edge that closes their read cycle. The bench changes inputs at the falling edge and checks the combinational results 5 ns later, before the next rising edge. It reads the registered results only after the following falling edge. Pointer changes are checked indirectly, through the address that the next push or pop presents.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_PUSH_W   = 3'd1,
    OP_POP_W    = 3'd2,
    OP_PUSH_PC  = 3'd3,
    OP_PUSH_PCF = 3'd4,
    OP_POP_PC   = 3'd5,
    OP_POP_PCF  = 3'd6
  } stk_op_e;

  typedef enum logic {SQ_IDLE = 1'b0, SQ_SECOND = 1'b1} sq_state_e;

  localparam logic [3:0] CAUSE_NONE = 4'd0;
  localparam logic [3:0] CAUSE_OVF  = 4'd1;
  localparam logic [3:0] CAUSE_UNF  = 4'd2;
endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_sync = s2_q;
endmodule

// File: rtl/stk_guard.sv
module stk_guard import stk_pkg::*; #(
  parameter int AW   = 16,
  parameter int BASE = 2047,
  parameter int TOP  = 4095
) (
  input  logic          en,
  input  stk_op_e       op,
  input  logic [AW-1:0] sp,
  output logic          is_push,
  output logic          is_pop,
  output logic          two_word,
  output logic          fault,
  output logic [3:0]    cause
);
  localparam logic [AW:0] BASE_X = (AW+1)'(BASE);
  localparam logic [AW:0] TOP_X  = (AW+1)'(TOP);

  logic [AW:0] sp_x, need;
  logic        ovf, unf;

  always_comb begin
    is_push  = 1'b0;
    is_pop   = 1'b0;
    two_word = 1'b0;
    if (en) begin
      case (op)
        OP_PUSH_W:               is_push = 1'b1;
        OP_POP_W:                is_pop  = 1'b1;
        OP_PUSH_PC, OP_PUSH_PCF: begin is_push = 1'b1; two_word = 1'b1; end
        OP_POP_PC, OP_POP_PCF:   begin is_pop  = 1'b1; two_word = 1'b1; end
        default: ;
      endcase
    end
  end

  assign sp_x  = {1'b0, sp};
  assign need  = two_word ? (AW+1)'(2) : (AW+1)'(1);
  assign ovf   = is_push && ((sp_x + need) > TOP_X);
  assign unf   = is_pop  && (sp_x < (BASE_X + need));
  assign fault = ovf | unf;
  assign cause = ovf ? CAUSE_OVF : (unf ? CAUSE_UNF : CAUSE_NONE);
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int AW   = 16,
  parameter int BASE = 2047,
  parameter int TOP  = 4095
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp,
  output logic [AW-1:0] sp_m1
);
  localparam logic [AW-1:0] BASE_A = AW'(BASE);
  localparam logic [AW-1:0] TOP_A  = AW'(TOP);

  logic [AW-1:0] sp_q, sp_d;
  logic          sp_en;

  assign sp_en = inc ^ dec;

  always_comb begin
    sp_d = sp_q;
    if (inc)      sp_d = sp_q + AW'(1);
    else if (dec) sp_d = sp_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= BASE_A;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp    = sp_q;
  assign sp_m1 = sp_q - AW'(1);

  // R7: the pointer never drops below the base
  p_sp_floor_r7: assert property (@(posedge clk) disable iff (!rst_n) sp_q >= BASE_A);
  // R8: the pointer never passes the top address
  p_sp_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n) sp_q <= TOP_A);
endmodule

// File: rtl/stk_seq.sv
module stk_seq import stk_pkg::*; #(
  parameter int DW       = 16,
  parameter int AW       = 16,
  parameter int PCW      = 28,
  parameter int FW       = 4,
  parameter int PC_OUT_W = 32,
  parameter int BASE     = 2047,
  parameter int TOP      = 4095
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd,
  input  logic [DW-1:0]       reg_wdata,
  input  logic [PCW-1:0]      pc_in,
  input  logic [FW-1:0]       flags_in,
  input  logic [DW-1:0]       mem_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic [DW-1:0]       reg_rdata,
  output logic [PC_OUT_W-1:0] pc_out,
  output logic [FW-1:0]       flags_out,
  output logic                busy,
  output logic [3:0]          cause
);
  localparam int PCHI  = PCW - DW;
  localparam int PCPAD = PC_OUT_W - PCW;

  logic          rstn_s;
  stk_op_e       op;
  sq_state_e     state_q, state_d;
  logic          in_second, accept;
  logic          is_push, is_pop, two_word, fault;
  logic [AW-1:0] sp, sp_m1;
  logic          sp_inc, sp_dec;
  logic [DW-1:0] hold_q, hold_d;
  logic          dir_push_q, rest_fl_q;
  logic          hold_en, word_en, pc_en, fl_en;
  logic [DW-1:0]       rdat_q;
  logic [PC_OUT_W-1:0] pc_q, pc_d;
  logic [FW-1:0]       fl_q;

  stk_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rstn_s));

  assign op        = stk_op_e'(cmd);
  assign in_second = (state_q == SQ_SECOND);

  stk_guard #(.AW(AW), .BASE(BASE), .TOP(TOP)) u_guard (
    .en(!in_second), .op(op), .sp(sp),
    .is_push(is_push), .is_pop(is_pop), .two_word(two_word),
    .fault(fault), .cause(cause)
  );

  stk_ptr #(.AW(AW), .BASE(BASE), .TOP(TOP)) u_ptr (
    .clk(clk), .rst_n(rstn_s), .inc(sp_inc), .dec(sp_dec), .sp(sp), .sp_m1(sp_m1)
  );

  assign accept = (is_push | is_pop) & ~fault;
  assign busy   = accept & two_word;

  // memory port and pointer stepping
  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp;
    mem_wdata = reg_wdata;
    sp_inc    = 1'b0;
    sp_dec    = 1'b0;
    if (in_second) begin
      if (dir_push_q) begin
        mem_we    = 1'b1;
        mem_wdata = hold_q;
        sp_inc    = 1'b1;
      end else begin
        mem_re   = 1'b1;
        mem_addr = sp_m1;
        sp_dec   = 1'b1;
      end
    end else if (accept) begin
      if (is_push) begin
        mem_we    = 1'b1;
        mem_wdata = two_word ? pc_in[DW-1:0] : reg_wdata;
        sp_inc    = 1'b1;
      end else begin
        mem_re   = 1'b1;
        mem_addr = sp_m1;
        sp_dec   = 1'b1;
      end
    end
  end

  // next-state values and clock enables
  always_comb begin
    state_d = busy ? SQ_SECOND : SQ_IDLE;
    hold_d  = is_push ? {flags_in, pc_in[PCW-1:DW]} : mem_rdata;
    hold_en = busy;
    word_en = accept & is_pop & ~two_word;
    pc_en   = in_second & ~dir_push_q;
    fl_en   = pc_en & rest_fl_q;
    pc_d    = {{PCPAD{1'b0}}, hold_q[PCHI-1:0], mem_rdata};
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s) begin
      hold_q     <= '0;
      dir_push_q <= 1'b0;
      rest_fl_q  <= 1'b0;
    end else if (hold_en) begin
      hold_q     <= hold_d;
      dir_push_q <= is_push;
      rest_fl_q  <= (op == OP_POP_PCF);
    end
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s)      rdat_q <= '0;
    else if (word_en) rdat_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rstn_s) begin
    if (!rstn_s)    fl_q <= '0;
    else if (fl_en) fl_q <= hold_q[DW-1:DW-FW];
  end

  assign reg_rdata = rdat_q;
  assign pc_out    = pc_q;
  assign flags_out = fl_q;

  // R4: busy lasts exactly one cycle
  p_busy_one_cycle_r4: assert property (@(posedge clk) disable iff (!rstn_s)
    busy |=> !busy);
  // R4: second write of a PC push lands one slot higher
  p_push_upper_r4: assert property (@(posedge clk) disable iff (!rstn_s)
    (busy && mem_we) |=> (mem_we && mem_addr == ($past(mem_addr) + AW'(1))));
  // R5: second read of a PC pop lands one slot lower
  p_pop_lower_r5: assert property (@(posedge clk) disable iff (!rstn_s)
    (busy && mem_re) |=> (mem_re && mem_addr == ($past(mem_addr) - AW'(1))));
  // R6: a plain PC pop keeps the flags
  p_flags_kept_r6: assert property (@(posedge clk) disable iff (!rstn_s)
    (in_second && !dir_push_q && !rest_fl_q) |=> $stable(flags_out));
  // R8: a fault issues no transfer
  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rstn_s)
    (cause != CAUSE_NONE) |-> (!mem_we && !mem_re && !busy));
  // R5: upper PC bits stay zero
  p_pc_top_zero_r5: assert property (@(posedge clk) disable iff (!rstn_s)
    pc_out[PC_OUT_W-1:PCW] == '0);
endmodule

// File: tb/sim_stk_seq.sv
module sim_stk_seq;
  localparam int TOPV = 2052;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cmd;
  logic [15:0] reg_wdata;
  logic [27:0] pc_in;
  logic [3:0]  flags_in;
  logic [15:0] mem_rdata;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_we, mem_re, busy;
  logic [15:0] reg_rdata;
  logic [31:0] pc_out;
  logic [3:0]  flags_out, cause;

  logic [15:0] mem [0:255];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stk_seq #(.TOP(TOPV)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .reg_wdata(reg_wdata), .pc_in(pc_in),
    .flags_in(flags_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re), .reg_rdata(reg_rdata),
    .pc_out(pc_out), .flags_out(flags_out), .busy(busy), .cause(cause)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [15:0] w = 16'h0,
                       input logic [27:0] pc = 28'h0, input logic [3:0] fl = 4'h0);
    @(negedge clk);
    cmd = op; reg_wdata = w; pc_in = pc; flags_in = fl;
    #5;
  endtask

  task automatic idle();
    drive(3'd0);
  endtask

  task automatic t_reset();
    chk("R1 we", {31'b0, mem_we}, 0);
    chk("R1 re", {31'b0, mem_re}, 0);
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 cause", {28'b0, cause}, 0);
    chk("R1 reg_rdata", {16'b0, reg_rdata}, 0);
    chk("R1 pc_out", pc_out, 0);
    chk("R1 flags_out", {28'b0, flags_out}, 0);
    chk("R9 none quiet", {30'b0, mem_we, mem_re}, 0);
  endtask

  task automatic t_push_word(input logic [15:0] w, input logic [15:0] addr);
    drive(3'd1, w);
    chk("R2 we", {31'b0, mem_we}, 1);
    chk("R2 addr", {16'b0, mem_addr}, {16'b0, addr});
    chk("R2 data", {16'b0, mem_wdata}, {16'b0, w});
    chk("R2 busy", {31'b0, busy}, 0);
    idle();
  endtask

  task automatic t_pop_word(input logic [15:0] addr, input logic [15:0] val);
    drive(3'd2);
    chk("R3 re", {31'b0, mem_re}, 1);
    chk("R3 addr", {16'b0, mem_addr}, {16'b0, addr});
    chk("R3 cause", {28'b0, cause}, 0);
    idle();
    chk("R3 reg_rdata", {16'b0, reg_rdata}, {16'b0, val});
  endtask

  task automatic t_push_pc(input logic [2:0] op, input logic [27:0] pc,
                           input logic [3:0] fl, input logic [15:0] addr);
    drive(op, 16'h0, pc, fl);
    chk("R4 first we", {31'b0, mem_we}, 1);
    chk("R4 first addr", {16'b0, mem_addr}, {16'b0, addr});
    chk("R4 first data", {16'b0, mem_wdata}, {16'b0, pc[15:0]});
    chk("R4 first busy", {31'b0, busy}, 1);
    drive(3'd2, 16'hDEAD, 28'h0, 4'h0); // R9: stray command in second cycle
    chk("R9 second we", {30'b0, mem_we, mem_re}, 2);
    chk("R4 second addr", {16'b0, mem_addr}, {16'b0, addr + 16'd1});
    chk("R4 second data", {16'b0, mem_wdata}, {16'b0, fl, pc[27:16]});
    chk("R4 second busy", {31'b0, busy}, 0);
    idle();
  endtask

  task automatic t_pop_pc(input logic [2:0] op, input logic [15:0] top_addr,
                          input logic [31:0] exp_pc, input logic [3:0] exp_fl);
    drive(op);
    chk("R5 first re", {31'b0, mem_re}, 1);
    chk("R5 first addr", {16'b0, mem_addr}, {16'b0, top_addr});
    chk("R5 first busy", {31'b0, busy}, 1);
    drive(op);
    chk("R5 second re", {31'b0, mem_re}, 1);
    chk("R5 second addr", {16'b0, mem_addr}, {16'b0, top_addr - 16'd1});
    chk("R5 second busy", {31'b0, busy}, 0);
    idle();
    chk("R5 pc_out", pc_out, exp_pc);
    chk("R6 flags_out", {28'b0, flags_out}, {28'b0, exp_fl});
  endtask

  task automatic t_fault(input logic [2:0] op, input logic [3:0] exp_cause, input string req);
    drive(op, 16'hBAD0, 28'hFFFFFFF, 4'hF);
    chk({req, " cause"}, {28'b0, cause}, {28'b0, exp_cause});
    chk({req, " strobes"}, {30'b0, mem_we, mem_re}, 0);
    chk({req, " busy"}, {31'b0, busy}, 0);
    idle();
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    rst_n = 1'b0; cmd = 3'd0; reg_wdata = '0; pc_in = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    t_reset();

    t_fault(3'd2, 4'd2, "R7 empty word pop");
    t_fault(3'd6, 4'd2, "R7 empty pc pop");
    t_push_word(16'hA5A5, 16'd2047);
    t_push_pc(3'd3, 28'hABC1234, 4'h9, 16'd2048);
    t_pop_pc(3'd5, 16'd2049, 32'h0ABC1234, 4'h0);
    t_push_pc(3'd4, 28'h1234567, 4'h6, 16'd2048);
    t_pop_pc(3'd6, 16'd2049, 32'h01234567, 4'h6);
    t_pop_word(16'd2047, 16'hA5A5);

    // R7: one word on the stack cannot satisfy a two-word pop
    t_push_word(16'h1111, 16'd2047);
    t_fault(3'd5, 4'd2, "R7 short pc pop");
    t_pop_word(16'd2047, 16'h1111);

    // R8: fill toward the top address
    t_push_word(16'h0001, 16'd2047);
    t_push_word(16'h0002, 16'd2048);
    t_push_word(16'h0003, 16'd2049);
    t_push_word(16'h0004, 16'd2050);
    t_fault(3'd3, 4'd1, "R8 pc push near top");
    t_push_word(16'h0005, 16'd2051);
    t_fault(3'd1, 4'd1, "R8 word push at top");
    t_pop_word(16'd2051, 16'h0005);
    t_pop_word(16'd2050, 16'h0004);

    // R9: idle cycles leave the pointer unchanged
    idle();
    chk("R9 idle strobes", {30'b0, mem_we, mem_re}, 0);
    idle();
    t_pop_word(16'd2049, 16'h0003);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule